// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block picks the handshake that a USB device function returns on a single endpoint. Each token that the packet decoder delivers (SETUP, IN or OUT) is answered one clock later with a response code: no handshake, ACK, NAK, STALL, a data packet, or a zero-length data packet. The block also drives the data PID that the transmitter should use, and tracks the state behind these answers: the data toggle, a stall flag, and a status-acknowledge flag. Firmware arms the status-acknowledge flag to release the status stage of a control transfer.

Several inputs shape the answer. The endpoint enable and the endpoint type give the endpoint's configuration. The data-stage-complete flag marks control IN and OUT tokens as status-stage tokens. A pulse from the receive path reports that the host acknowledged the last packet the device sent. The status-acknowledge flag clears itself when the status handshake completes or when a new SETUP arrives, and no interrupt is raised when it does. Stalling leaves the data toggle where it was, and only re-enabling the endpoint returns it to DATA0.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After reset, resp_o is 0 (no handshake) and data_pid_o is 0 (DATA0).
- R2: While ep_en_i is 0, every token gets response 0 (no handshake). A 0-to-1 transition of ep_en_i sets the data toggle to DATA0.
- R3: Tokens are coded on tok_i as 0 none, 1 OUT, 2 IN and 3 SETUP. Endpoint types are coded on ep_type_i as 0 control, 1 isochronous, 2 bulk and 3 interrupt. Response codes on resp_o are 0 none, 1 ACK, 2 NAK, 3 STALL, 4 DATA and 5 zero-length DATA. A token is answered in the cycle after it is presented. On an enabled, unstalled data-stage token, IN gets 4 and OUT gets 1.
- R4: On a non-isochronous endpoint, the toggle flips when a data-stage OUT is answered with ACK, and when host_ack_i pulses while no token is present and the last answer was a data packet. An isochronous endpoint never flips the toggle.
- R5: While the stall flag is set (stall_set_i sets it, stall_clr_i clears it), IN and OUT tokens on a non-isochronous endpoint get 3. The toggle is held while stalled and continues from the same value after the stall is cleared.
- R6: The stall flag has no effect on an isochronous endpoint.
- R7: A control IN or OUT token with data_done_i high is a status-stage token. It gets 2 while the status-acknowledge flag is 0. With the flag at 1, an IN status token gets 5 and an OUT status token gets 1.
- R8: The status-acknowledge flag clears itself when an OUT status token is answered with ACK, and when host_ack_i pulses after a zero-length packet was sent.
- R9: A SETUP on an enabled control endpoint gets 1. It also sets the toggle to DATA1 and clears both the stall flag and the status-acknowledge flag. A SETUP on any other endpoint type gets 0.
- R10: A status_set_i pulse while data_done_i is 0 is ignored.
- R11: The status-acknowledge flag and status-stage answers apply only to control endpoints. On other types, status_set_i is ignored and tokens get data-stage answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ep_en_i | input | 1 | Endpoint enable level |
| ep_type_i | input | 2 | Endpoint type code |
| tok_i | input | 2 | Decoded token of the current cycle |
| data_done_i | input | 1 | Control data stage fully complete |
| host_ack_i | input | 1 | Host acknowledged the last packet sent |
| stall_set_i | input | 1 | Firmware pulse that sets the stall flag |
| stall_clr_i | input | 1 | Firmware pulse that clears the stall flag |
| status_set_i | input | 1 | Firmware pulse that sets the status-acknowledge flag |
| resp_o | output | 3 | Registered response code |
| data_pid_o | output | 1 | Current data toggle (0 DATA0, 1 DATA1) |

## Verification
The bench runs the same token kinds through bulk, isochronous and control configurations. Identical tokens that get different answers show that the type, stall and status decoding each work. Runs of OUT tokens and of IN tokens followed by host acknowledges tell a toggle that flips from one that only follows tokens. Runs through a stall and through a disable and re-enable tell a held toggle from a reset one. Status-set pulses given before and after the data stage completes, and SETUP tokens placed inside an armed status stage, separate a flag that is ignored, one that clears itself and one that is cleared by SETUP.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int TOK_W  = 2;
  localparam int TYPE_W = 2;
  localparam int RSP_W  = 3;

  typedef enum logic [TOK_W-1:0] {
    TOK_NONE  = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_SETUP = 2'd3
  } tok_e;

  typedef enum logic [TYPE_W-1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_type_e;

  typedef enum logic [RSP_W-1:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4,
    RSP_ZLP   = 3'd5
  } rsp_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_DATA = 2'd1,
    PEND_ZLP  = 2'd2
  } pend_e;
endpackage

// File: rtl/ep_hs_status.sv
module ep_hs_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic allow_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // clear wins over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (clr_i)            flag_q <= 1'b0;
    else if (set_i && allow_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ep_hs_state.sv
module ep_hs_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic setup_i,
  input  logic flip_i,
  input  logic stall_set_i,
  input  logic stall_clr_i,
  output logic toggle_o,
  output logic stall_o
);
  logic en_q, tgl_q, stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (setup_i)           tgl_q <= 1'b1;
      else if (en_i && !en_q) tgl_q <= 1'b0;
      else if (flip_i)        tgl_q <= ~tgl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    stall_q <= 1'b0;
    else if (setup_i || stall_clr_i) stall_q <= 1'b0;
    else if (stall_set_i)            stall_q <= 1'b1;
  end

  assign toggle_o = tgl_q;
  assign stall_o  = stall_q;
endmodule

// File: rtl/ep_hs_resp.sv
module ep_hs_resp
  import ep_hs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  tok_e     tok_i,
  input  ep_type_e type_i,
  input  logic     data_done_i,
  input  logic     host_ack_i,
  input  logic     stall_i,
  input  logic     flag_i,
  output rsp_e     resp_o,
  output logic     setup_o,
  output logic     flip_o,
  output logic     status_done_o
);
  rsp_e  rsp_d, rsp_q;
  pend_e pend_d, pend_q;
  logic  is_ctrl, is_iso, io_tok, status_stg, stall_eff, ack_evt;

  assign is_ctrl    = (type_i == EP_CTRL);
  assign is_iso     = (type_i == EP_ISO);
  assign io_tok     = (tok_i == TOK_IN) || (tok_i == TOK_OUT);
  assign status_stg = is_ctrl && data_done_i && io_tok;
  assign stall_eff  = stall_i && !is_iso;
  assign ack_evt    = host_ack_i && (tok_i == TOK_NONE);

  always_comb begin
    rsp_d = RSP_NONE;
    if (en_i && tok_i != TOK_NONE) begin
      if (tok_i == TOK_SETUP)   rsp_d = is_ctrl ? RSP_ACK : RSP_NONE;
      else if (stall_eff)       rsp_d = RSP_STALL;
      else if (status_stg)      rsp_d = !flag_i ? RSP_NAK :
                                        (tok_i == TOK_IN) ? RSP_ZLP : RSP_ACK;
      else                      rsp_d = (tok_i == TOK_IN) ? RSP_DATA : RSP_ACK;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (tok_i != TOK_NONE) begin
      if (rsp_d == RSP_DATA && !is_iso) pend_d = PEND_DATA;
      else if (rsp_d == RSP_ZLP)        pend_d = PEND_ZLP;
      else                              pend_d = PEND_NONE;
    end else if (host_ack_i) begin
      pend_d = PEND_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q  <= RSP_NONE;
      pend_q <= PEND_NONE;
    end else begin
      rsp_q  <= rsp_d;
      pend_q <= pend_d;
    end
  end

  assign setup_o       = en_i && is_ctrl && (tok_i == TOK_SETUP);
  assign flip_o        = (rsp_d == RSP_ACK && tok_i == TOK_OUT && !status_stg && !is_iso)
                       || (ack_evt && pend_q == PEND_DATA);
  assign status_done_o = (rsp_d == RSP_ACK && tok_i == TOK_OUT && status_stg)
                       || (ack_evt && pend_q == PEND_ZLP);
  assign resp_o        = rsp_q;
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import ep_hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep_en_i,
  input  logic [TYPE_W-1:0] ep_type_i,
  input  logic [TOK_W-1:0]  tok_i,
  input  logic              data_done_i,
  input  logic              host_ack_i,
  input  logic              stall_set_i,
  input  logic              stall_clr_i,
  input  logic              status_set_i,
  output logic [RSP_W-1:0]  resp_o,
  output logic              data_pid_o
);
  ep_type_e typ;
  rsp_e     rsp;
  logic     setup_hit, flip, status_done, stall, flag;

  assign typ = ep_type_e'(ep_type_i);

  ep_hs_resp u_resp (
    .clk_i, .rst_ni,
    .en_i          (ep_en_i),
    .tok_i         (tok_e'(tok_i)),
    .type_i        (typ),
    .data_done_i,
    .host_ack_i,
    .stall_i       (stall),
    .flag_i        (flag),
    .resp_o        (rsp),
    .setup_o       (setup_hit),
    .flip_o        (flip),
    .status_done_o (status_done)
  );

  ep_hs_state u_state (
    .clk_i, .rst_ni,
    .en_i        (ep_en_i),
    .setup_i     (setup_hit),
    .flip_i      (flip),
    .stall_set_i,
    .stall_clr_i,
    .toggle_o    (data_pid_o),
    .stall_o     (stall)
  );

  ep_hs_status u_status (
    .clk_i, .rst_ni,
    .set_i   (status_set_i),
    .allow_i (data_done_i && typ == EP_CTRL),
    .clr_i   (setup_hit || status_done),
    .flag_o  (flag)
  );

  assign resp_o = rsp;
endmodule

// File: rtl/ep_hs_ctrl_chk.sv
module ep_hs_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ep_en_i,
  input logic [1:0] ep_type_i,
  input logic [1:0] tok_i,
  input logic       data_done_i,
  input logic [2:0] resp_o,
  input logic       data_pid_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_RESP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o <= 3'd5); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ep_en_i) |-> resp_o == 3'd0); // R2
  AST_ZLP_ONLY_STATUS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && resp_o == 3'd5 |-> $past(tok_i) == 2'd2 && $past(ep_type_i) == 2'd0 && $past(data_done_i)); // R7
  AST_NAK_ONLY_CONTROL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && resp_o == 3'd2 |-> $past(ep_type_i) == 2'd0); // R11
  AST_NO_ISO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && resp_o == 3'd3 |-> $past(ep_type_i) != 2'd1); // R6
  AST_SETUP_ACK_DATA1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ep_en_i && tok_i == 2'd3 && ep_type_i == 2'd0) |-> resp_o == 3'd1 && data_pid_o); // R9
endmodule

bind ep_hs_ctrl ep_hs_ctrl_chk u_chk (
  .clk_i, .rst_ni, .ep_en_i, .ep_type_i, .tok_i, .data_done_i, .resp_o, .data_pid_o
);

// File: tb/ep_hs_ctrl_tb_top.sv
module ep_hs_ctrl_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ep_en_i = 1'b0, data_done_i = 1'b0, host_ack_i = 1'b0;
  logic stall_set_i = 1'b0, stall_clr_i = 1'b0, status_set_i = 1'b0;
  logic [1:0] ep_type_i = 2'd0, tok_i = 2'd0;
  logic [2:0] resp_o;
  logic data_pid_o;

  always #2.5 clk_i = ~clk_i;

  ep_hs_ctrl dut_i (.*);

  typedef struct {
    int         due;
    logic [2:0] rsp;
    logic       pid;
    string      req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      automatic exp_t e = q.pop_front();
      checks++;
      if (resp_o !== e.rsp || data_pid_o !== e.pid) begin
        fails++;
        $display("FAIL %s: resp=%0d pid=%0d expected resp=%0d pid=%0d",
                 e.req, resp_o, data_pid_o, e.rsp, e.pid);
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic [2:0] r, input logic p, input string req);
    exp_t e;
    @(negedge clk_i);
    tok_i = k;
    e.due = cyc + 1; e.rsp = r; e.pid = p; e.req = req;
    q.push_back(e);
    @(negedge clk_i);
    tok_i = 2'd0;
  endtask

  task automatic hack();
    @(negedge clk_i); host_ack_i = 1'b1;
    @(negedge clk_i); host_ack_i = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk_i);
    case (which)
      0: stall_set_i = 1'b1;
      1: stall_clr_i = 1'b1;
      default: status_set_i = 1'b1;
    endcase
    @(negedge clk_i);
    stall_set_i = 1'b0; stall_clr_i = 1'b0; status_set_i = 1'b0;
  endtask

  localparam logic [1:0] OUT = 2'd1, IN = 2'd2, SETUP = 2'd3;
  localparam logic [1:0] CTRL = 2'd0, ISO = 2'd1, BULK = 2'd2;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (resp_o !== 3'd0 || data_pid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: resp=%0d pid=%0d expected resp=0 pid=0", resp_o, data_pid_o);
    end

    send(IN, 3'd0, 1'b0, "R2 disabled");
    @(negedge clk_i); ep_en_i = 1'b1; ep_type_i = BULK;
    send(OUT, 3'd1, 1'b1, "R3 out ack / R4 flip");
    send(OUT, 3'd1, 1'b0, "R4 flip back");
    send(IN,  3'd4, 1'b0, "R3 in data");
    hack();
    send(IN,  3'd4, 1'b1, "R4 host ack flip");
    hack();
    send(OUT, 3'd1, 1'b1, "R4 out after ack");

    pulse(0);
    send(IN,  3'd3, 1'b1, "R5 stall in");
    send(OUT, 3'd3, 1'b1, "R5 stall out holds pid");
    hack();
    pulse(1);
    send(OUT, 3'd1, 1'b0, "R5 resume toggle");
    send(OUT, 3'd1, 1'b1, "R5 resume toggle 2");
    @(negedge clk_i); ep_en_i = 1'b0;
    @(negedge clk_i); ep_en_i = 1'b1;
    send(IN,  3'd4, 1'b0, "R2 reenable resets toggle");

    ep_type_i = ISO;
    pulse(0);
    send(IN,  3'd4, 1'b0, "R6 iso ignores stall");
    hack();
    send(OUT, 3'd1, 1'b0, "R4 iso no flip");
    pulse(1);

    ep_type_i = CTRL; data_done_i = 1'b0;
    send(SETUP, 3'd1, 1'b1, "R9 setup ack data1");
    send(IN,  3'd4, 1'b1, "R3 control data stage");
    hack();
    pulse(2);
    @(negedge clk_i); data_done_i = 1'b1;
    send(OUT, 3'd2, 1'b0, "R10 early set ignored");
    pulse(2);
    send(OUT, 3'd1, 1'b0, "R7 status out ack");
    send(OUT, 3'd2, 1'b0, "R8 cleared after out status");
    pulse(2);
    send(IN,  3'd5, 1'b0, "R7 status in zlp");
    send(IN,  3'd5, 1'b0, "R8 held until host ack");
    hack();
    send(IN,  3'd2, 1'b0, "R8 cleared after zlp ack");
    pulse(2);
    send(SETUP, 3'd1, 1'b1, "R9 setup with flag");
    send(IN,  3'd2, 1'b1, "R9 setup cleared flag");
    pulse(0);
    send(IN,  3'd3, 1'b1, "R5 control stall");
    send(SETUP, 3'd1, 1'b1, "R9 setup while stalled");
    send(OUT, 3'd2, 1'b1, "R9 setup cleared stall");

    ep_type_i = BULK;
    send(SETUP, 3'd0, 1'b1, "R9 setup on bulk");
    pulse(2);
    send(IN,  3'd4, 1'b1, "R11 bulk no status stage");
    ep_type_i = CTRL;
    send(IN,  3'd2, 1'b1, "R11 bulk set ignored");

    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule